// File: doc/BRIEF.md
# Multi-Digit Decimal Adder

This block adds two unsigned decimal numbers, each packed as four-bit digit codes (0000 for zero up to 1001 for nine, every digit coded by itself), together with an incoming carry. It returns the decimal sum in the same packed form plus a carry out of the top digit. It suits counters, display pipelines and accumulators that keep their values in decimal form.

Every digit position is one slice. An ordinary binary adder first forms a five-bit raw value from the two digits and the carry arriving from below. A gate-level test then decides whether that raw value is above nine. The test fires on a raw low nibble of 1010 to 1111, or on a binary carry out for raw values of 16 and above. When it fires, a second binary adder adds six to the raw low nibble, and the slice sends a decimal carry to the next slice up. The slices ripple from the least significant digit to the most significant.

A flag reports any input digit code that is not a legal decimal digit. The result path is combinational. A parameter adds one register stage, with an active-low asynchronous reset, on all outputs.

Top module: `bcd_ripple_adder`

## Requirements
- R1: In a slice whose raw value (digit A + digit B + carry in) is 0 to 9, the output digit equals the raw value and the slice sends no carry upward.
- R2: In a slice whose raw value is 10 to 15, the output digit is the low four bits of raw + 6, and the slice sends a carry of 1 upward.
- R3: In a slice whose raw value is 16 to 19, the output digit is raw − 10 (0 to 9), and the slice sends a carry of 1 upward.
- R4: `carry_in` enters digit 0. Each slice's carry feeds the slice above it, and `carry_out` is the carry of the top slice. For example, 99999 + 00000 + 1 gives sum 00000 with `carry_out` = 1.
- R5: With legal inputs, {`carry_out`, `sum_bcd`} is the decimal value A + B + `carry_in` in packed form. Digit d occupies bits 4d+3..4d, and the maximum is 99999 + 99999 + 1 = 1 99999.
- R6: `bad_digit` is 1 exactly when any nibble of `a_bcd` or `b_bcd` lies in 1010..1111. The sum digits are then don't-care.
- R7: With REG_OUT = 1, every output shows the result of the inputs present at the previous rising clock edge and holds steady between edges. While `rst_n` is low, every output is 0.
- R8: With legal inputs, every nibble of `sum_bcd` is a legal decimal digit (0 to 9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| a_bcd | input | 4*DIGITS | First operand, packed decimal digits |
| b_bcd | input | 4*DIGITS | Second operand, packed decimal digits |
| carry_in | input | 1 | Decimal carry into digit 0 |
| sum_bcd | output | 4*DIGITS | Packed decimal sum |
| carry_out | output | 1 | Decimal carry out of the top digit |
| bad_digit | output | 1 | Some input nibble is not a legal digit |

## Verification
The checker's arithmetic properties assume legal operand digits, and they apply only while `bad_digit` is low. Only the flag property looks at illegal codes. The stimulus keeps the sum checks to operands built from digits 0 to 9: an exhaustive sweep of one digit pair with both carry values, random five-digit operands, and the all-nines extremes. Illegal nibbles appear only in dedicated cases, and those cases check only the flag. The checker also assumes that the inputs are sampled at each rising edge, and the bench changes them only on falling edges.

// File: rtl/bcd_ripple_adder.sv
module bcd_ripple_adder #(
  parameter int DIGITS  = 5,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [4*DIGITS-1:0] a_bcd,
  input  logic [4*DIGITS-1:0] b_bcd,
  input  logic                carry_in,
  output logic [4*DIGITS-1:0] sum_bcd,
  output logic                carry_out,
  output logic                bad_digit
);
  localparam int W = 4 * DIGITS;

  logic [DIGITS:0]   carry;
  logic [W-1:0]      sum_c;
  logic [DIGITS-1:0] bad_c;

  assign carry[0] = carry_in;

  for (genvar d = 0; d < DIGITS; d++) begin : g_slice
    logic [3:0] da, db;
    logic [4:0] raw;
    logic       over9, fix;
    assign da    = a_bcd[4*d +: 4];
    assign db    = b_bcd[4*d +: 4];
    assign raw   = {1'b0, da} + {1'b0, db} + {4'b0000, carry[d]};
    assign over9 = raw[3] & (raw[2] | raw[1]);
    assign fix   = raw[4] | over9;
    assign sum_c[4*d +: 4] = raw[3:0] + (fix ? 4'd6 : 4'd0);
    assign carry[d+1] = fix;
    assign bad_c[d]   = (da > 4'd9) | (db > 4'd9);
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum_bcd   <= '0;
        carry_out <= 1'b0;
        bad_digit <= 1'b0;
      end else begin
        sum_bcd   <= sum_c;
        carry_out <= carry[DIGITS];
        bad_digit <= |bad_c;
      end
    end
  end else begin : g_comb
    assign sum_bcd   = sum_c;
    assign carry_out = carry[DIGITS];
    assign bad_digit = |bad_c;
  end
endmodule

// File: rtl/bcd_ripple_adder_chk.sv
module bcd_ripple_adder_chk #(
  parameter int DIGITS  = 5,
  parameter bit REG_OUT = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [4*DIGITS-1:0] a_bcd,
  input logic [4*DIGITS-1:0] b_bcd,
  input logic                carry_in,
  input logic [4*DIGITS-1:0] sum_bcd,
  input logic                carry_out,
  input logic                bad_digit
);
  localparam int W = 4 * DIGITS;

  function automatic bit all_legal(input logic [W-1:0] v);
    bit ok = 1'b1;
    for (int i = 0; i < DIGITS; i++) if (v[4*i +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  function automatic bit all_nines(input logic [W-1:0] v);
    bit ok = 1'b1;
    for (int i = 0; i < DIGITS; i++) if (v[4*i +: 4] != 4'd9) ok = 1'b0;
    return ok;
  endfunction

  logic [W-1:0] a_d, b_d;
  logic         c_d;

  if (REG_OUT) begin : g_dly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_d <= '0; b_d <= '0; c_d <= 1'b0;
      end else begin
        a_d <= a_bcd; b_d <= b_bcd; c_d <= carry_in;
      end
    end
  end else begin : g_now
    assign a_d = a_bcd;
    assign b_d = b_bcd;
    assign c_d = carry_in;
  end

  p_legal_digits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_digit |-> all_legal(sum_bcd));

  p_low_bad_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_d[3:0] > 4'd9 || b_d[3:0] > 4'd9) |-> bad_digit);

  p_add_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (b_d == '0 && !c_d && !bad_digit) |-> (sum_bcd == a_d && !carry_out));

  p_ripple_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (all_nines(a_d) && b_d == '0 && c_d) |-> (sum_bcd == '0 && carry_out));

  p_max_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (all_nines(a_d) && all_nines(b_d) && c_d) |-> (all_nines(sum_bcd) && carry_out));
endmodule

bind bcd_ripple_adder bcd_ripple_adder_chk #(.DIGITS(DIGITS), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_bcd(a_bcd), .b_bcd(b_bcd), .carry_in(carry_in),
  .sum_bcd(sum_bcd), .carry_out(carry_out), .bad_digit(bad_digit)
);

// File: tb/bcd_ripple_adder_tb.sv
`timescale 1ns/1ps
module bcd_ripple_adder_tb;
  localparam int DIGITS = 5;
  localparam int W = 4 * DIGITS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] a_bcd = '0, b_bcd = '0;
  logic carry_in = 1'b0;
  logic [W-1:0] sum_bcd;
  logic carry_out, bad_digit;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bcd_ripple_adder #(.DIGITS(DIGITS), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .a_bcd(a_bcd), .b_bcd(b_bcd), .carry_in(carry_in),
    .sum_bcd(sum_bcd), .carry_out(carry_out), .bad_digit(bad_digit));

  function automatic logic [W-1:0] to_bcd(input longint v);
    logic [W-1:0] r = '0;
    for (int i = 0; i < DIGITS; i++) begin
      r[4*i +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input int a, input int b, input bit c, input string req);
    longint s = longint'(a) + longint'(b) + longint'(c);
    longint lim = 1;
    for (int i = 0; i < DIGITS; i++) lim = lim * 10;
    @(negedge clk);
    a_bcd = to_bcd(a); b_bcd = to_bcd(b); carry_in = c;
    @(posedge clk); #1;
    check(sum_bcd == to_bcd(s % lim), req, longint'(sum_bcd), longint'(to_bcd(s % lim)));
    check(carry_out == (s >= lim), {req, " carry"}, longint'(carry_out), longint'(s >= lim));
    check(bad_digit == 1'b0, "R6 legal", longint'(bad_digit), 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    a_bcd = to_bcd(12345); b_bcd = to_bcd(54321); carry_in = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(sum_bcd == '0 && !carry_out && !bad_digit, "R7 reset", longint'(sum_bcd), 0);
    @(negedge clk); rst_n = 1'b1;

    for (int a = 0; a < 10; a++)
      for (int b = 0; b < 10; b++)
        for (int c = 0; c < 2; c++) begin
          int raw = a + b + c;
          apply(a, b, bit'(c), raw <= 9 ? "R1" : (raw <= 15 ? "R2" : "R3"));
        end

    apply(99999, 0, 1'b1, "R4 ripple");
    apply(99999, 99999, 1'b1, "R5 max");
    apply(99999, 99999, 1'b0, "R5");
    apply(0, 0, 1'b0, "R5 zero");
    apply(45555, 54444, 1'b1, "R4 chain");
    for (int i = 0; i < 400; i++)
      apply(int'($urandom_range(99999)), int'($urandom_range(99999)), bit'($urandom_range(1)), "R5 R8 rand");

    apply(31415, 27182, 1'b0, "R7 latency");
    @(negedge clk);
    a_bcd = to_bcd(11111); b_bcd = to_bcd(22222); carry_in = 1'b0;
    #1;
    check(sum_bcd == to_bcd(58597), "R7 hold", longint'(sum_bcd), longint'(to_bcd(58597)));

    for (int p = 0; p < 2 * DIGITS; p++) begin
      @(negedge clk);
      a_bcd = to_bcd(12345); b_bcd = to_bcd(67890); carry_in = 1'b0;
      if (p < DIGITS) a_bcd[4*p +: 4] = 4'hA + 4'(p % 6);
      else            b_bcd[4*(p-DIGITS) +: 4] = 4'hF - 4'(p % 6);
      @(posedge clk); #1;
      check(bad_digit == 1'b1, "R6 flag", longint'(bad_digit), 1);
    end
    apply(9, 9, 1'b0, "R6 clear");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule